// File: doc/BRIEF.md
# Nested Loop Counter Sequencer

This block runs the two-level loop step that follows an instruction marked for loop testing. It holds two table pointers, an outer one and an inner one, and a virtual program counter. Each pointer has a small descriptor in byte memory just below the address it points to: a count byte, a link word and a program-counter word. The block reads and updates these descriptors through a single byte-wide memory port. When the step is finished it presents the new pointer and counter values and pulses `done_o`.

A caller raises `start_i` for one cycle while the block is idle. On the same cycle it drives `jump_i` high to request a jump-loop step, or low for a plain loop test. The memory port uses a valid/ready request channel. The block holds address, write flag and write data stable while `mem_req_valid` is high and `mem_req_ready` is low. A request transfers on a cycle where both are high. For an accepted read, the memory must present the byte on `mem_rdata` in the very next cycle. That return path has no back-pressure. The memory may hold `mem_req_ready` low for any number of cycles.

Top module: `nlc_seq`

## Requirements
- R1: After reset, `fp0_o`, `fp1_o` and `vpc_o` equal the parameters RST_FP0, RST_FP1 and RST_VPC. `done_o` and `mem_req_valid` are low.
- R2: Each step first reads the outer count byte at fp0-4. If that byte is non-zero, the block writes the value minus one back to the same address.
- R3: If the outer count is zero, no count is written, and the new fp0 is the word read at the old fp0-2.
- R4: If the outer count is zero, the new fp1 is the word at the new fp0-8, and the new virtual PC is the word at the new fp0-6. The inner count is not examined.
- R5: If the outer count is non-zero, the block reads the inner count byte at fp1-4. If that byte is zero, the new fp1 is the word at the old fp1-2, and no inner count is written.
- R6: If both counts are non-zero, the inner count minus one is written back to fp1-4, and fp1 is unchanged.
- R7: For a jump-loop step with a non-zero outer count, the new virtual PC is the word at the updated fp1-6. For a plain step with a non-zero outer count, the virtual PC keeps its value.
- R8: A word is two bytes, low byte at the lower address. All address arithmetic wraps modulo 2^16.
- R9: The outputs change only on the cycle `done_o` is high. `done_o` lasts one cycle per step. A `start_i` pulse during a step has no effect.
- R10: An unaccepted request keeps its address, write flag and write data on the next cycle. A read result is taken from `mem_rdata` one cycle after acceptance.
- R11: `jump_i` is sampled only together with `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin one loop step (idle only) |
| jump_i | input | 1 | 1 = jump-loop step, 0 = plain loop test |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 16 | Byte address |
| mem_req_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, one cycle after acceptance |
| fp0_o | output | 16 | Outer table pointer |
| fp1_o | output | 16 | Inner table pointer |
| vpc_o | output | 16 | Virtual program counter |
| done_o | output | 1 | Step finished; outputs updated this cycle |

## Verification
The bench builds the block with DW=8 and with the following reset values:

| Parameter | Value |
|---|---|
| RST_FP0 | 16'h0003 |
| RST_FP1 | 16'h4000 |
| RST_VPC | 16'h1234 |

With fp0 at 16'h0003, the outer count sits at 16'hFFFF and its link word straddles 16'h0001 and 16'h0002. This exercises the address wrap from the first step. The descriptor chain the bench lays out passes through zero and non-zero outer counts, and through zero and non-zero inner counts, under both step kinds. The first phase runs with a pseudo-random ready signal, so the stall-hold rules are exercised. The second phase runs with ready held high, to reach the back-to-back timing.

// File: rtl/nlc_pkg.sv
package nlc_pkg;
  typedef enum logic [4:0] {
    S_IDLE,
    S_OC_RD, S_OC_WR,
    S_F0_LO, S_F0_HI,
    S_F1Z_LO, S_F1Z_HI,
    S_PCZ_LO, S_PCZ_HI,
    S_IC_RD, S_IC_WR,
    S_F1N_LO, S_F1N_HI,
    S_PCJ_LO, S_PCJ_HI,
    S_DONE
  } state_t;

  // distances below a pointer
  localparam int unsigned OFF_CNT  = 4;
  localparam int unsigned OFF_LINK = 2;
  localparam int unsigned OFF_PC   = 6;
  localparam int unsigned OFF_NXT1 = 8;
endpackage

// File: rtl/nlc_addr_sel.sv
module nlc_addr_sel
  import nlc_pkg::*;
#(
  parameter int PW = 16
) (
  input  state_t          st,
  input  logic [PW-1:0]   w0,
  input  logic [PW-1:0]   w1,
  output logic [PW-1:0]   addr
);
  localparam int OW = 4;
  logic          use_w1;
  logic [OW-1:0] off;

  always_comb begin
    use_w1 = 1'b0;
    off    = '0;
    unique case (st)
      S_OC_RD, S_OC_WR:   off = OW'(OFF_CNT);
      S_F0_LO:            off = OW'(OFF_LINK);
      S_F0_HI:            off = OW'(OFF_LINK - 1);
      S_F1Z_LO:           off = OW'(OFF_NXT1);
      S_F1Z_HI:           off = OW'(OFF_NXT1 - 1);
      S_PCZ_LO:           off = OW'(OFF_PC);
      S_PCZ_HI:           off = OW'(OFF_PC - 1);
      S_IC_RD, S_IC_WR:   begin use_w1 = 1'b1; off = OW'(OFF_CNT); end
      S_F1N_LO:           begin use_w1 = 1'b1; off = OW'(OFF_LINK); end
      S_F1N_HI:           begin use_w1 = 1'b1; off = OW'(OFF_LINK - 1); end
      S_PCJ_LO:           begin use_w1 = 1'b1; off = OW'(OFF_PC); end
      S_PCJ_HI:           begin use_w1 = 1'b1; off = OW'(OFF_PC - 1); end
      default:            off = '0;
    endcase
  end

  assign addr = (use_w1 ? w1 : w0) - PW'(off);
endmodule

// File: rtl/nlc_rsp_track.sv
module nlc_rsp_track #(
  parameter int PW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_ready,
  input  logic          req_we,
  input  logic [PW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= req_valid && req_ready && !req_we;
  end

  // R10: a stalled request is held unchanged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
                                   && $stable(req_we) && $stable(req_wdata)));
endmodule

// File: rtl/nlc_seq.sv
module nlc_seq
  import nlc_pkg::*;
#(
  parameter int               DW      = 8,
  parameter logic [2*DW-1:0]  RST_FP0 = '0,
  parameter logic [2*DW-1:0]  RST_FP1 = '0,
  parameter logic [2*DW-1:0]  RST_VPC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             jump_i,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_we,
  output logic [2*DW-1:0]  mem_req_addr,
  output logic [DW-1:0]    mem_req_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic [2*DW-1:0]  fp0_o,
  output logic [2*DW-1:0]  fp1_o,
  output logic [2*DW-1:0]  vpc_o,
  output logic             done_o
);
  localparam int PW = 2 * DW;

  state_t        st;
  logic [PW-1:0] w0, w1, wpc;
  logic [DW-1:0] lo_q, wdat_q;
  logic          jump_q;
  logic          rsp_v;
  logic          is_rd, is_wr, cap, hs, rzero;
  logic [PW-1:0] word_in;

  nlc_addr_sel #(.PW(PW)) u_addr (
    .st(st), .w0(w0), .w1(w1), .addr(mem_req_addr)
  );

  nlc_rsp_track #(.PW(PW), .DW(DW)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .req_valid(mem_req_valid), .req_ready(mem_req_ready),
    .req_we(mem_req_we), .req_addr(mem_req_addr),
    .req_wdata(mem_req_wdata), .rsp_valid(rsp_v)
  );

  always_comb begin
    is_rd = st inside {S_OC_RD, S_F0_LO, S_F0_HI, S_F1Z_LO, S_F1Z_HI,
                       S_PCZ_LO, S_PCZ_HI, S_IC_RD, S_F1N_LO, S_F1N_HI,
                       S_PCJ_LO, S_PCJ_HI};
    is_wr = st inside {S_OC_WR, S_IC_WR};
  end

  assign mem_req_valid = (is_rd && !rsp_v) || is_wr;
  assign mem_req_we    = is_wr;
  assign mem_req_wdata = wdat_q;
  assign cap           = is_rd && rsp_v;
  assign hs            = mem_req_valid && mem_req_ready;
  assign rzero         = (mem_rdata == '0);
  assign word_in       = {mem_rdata, lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      w0     <= RST_FP0;
      w1     <= RST_FP1;
      wpc    <= RST_VPC;
      lo_q   <= '0;
      wdat_q <= '0;
      jump_q <= 1'b0;
      fp0_o  <= RST_FP0;
      fp1_o  <= RST_FP1;
      vpc_o  <= RST_VPC;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        S_IDLE: if (start_i) begin
          w0     <= fp0_o;
          w1     <= fp1_o;
          wpc    <= vpc_o;
          jump_q <= jump_i;
          st     <= S_OC_RD;
        end
        S_OC_RD: if (cap) begin
          if (rzero) st <= S_F0_LO;
          else begin
            wdat_q <= mem_rdata - 1'b1;
            st     <= S_OC_WR;
          end
        end
        S_OC_WR: if (hs) st <= S_IC_RD;
        S_F0_LO: if (cap) begin lo_q <= mem_rdata; st <= S_F0_HI; end
        S_F0_HI: if (cap) begin w0 <= word_in; st <= S_F1Z_LO; end
        S_F1Z_LO: if (cap) begin lo_q <= mem_rdata; st <= S_F1Z_HI; end
        S_F1Z_HI: if (cap) begin w1 <= word_in; st <= S_PCZ_LO; end
        S_PCZ_LO: if (cap) begin lo_q <= mem_rdata; st <= S_PCZ_HI; end
        S_PCZ_HI: if (cap) begin wpc <= word_in; st <= S_DONE; end
        S_IC_RD: if (cap) begin
          if (rzero) st <= S_F1N_LO;
          else begin
            wdat_q <= mem_rdata - 1'b1;
            st     <= S_IC_WR;
          end
        end
        S_IC_WR: if (hs) st <= jump_q ? S_PCJ_LO : S_DONE;
        S_F1N_LO: if (cap) begin lo_q <= mem_rdata; st <= S_F1N_HI; end
        S_F1N_HI: if (cap) begin
          w1 <= word_in;
          st <= jump_q ? S_PCJ_LO : S_DONE;
        end
        S_PCJ_LO: if (cap) begin lo_q <= mem_rdata; st <= S_PCJ_HI; end
        S_PCJ_HI: if (cap) begin wpc <= word_in; st <= S_DONE; end
        S_DONE: begin
          fp0_o  <= w0;
          fp1_o  <= w1;
          vpc_o  <= wpc;
          done_o <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9: one-cycle completion pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: visible state moves only with done
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(fp0_o) && $stable(fp1_o) && $stable(vpc_o)));

  // R3: a zero outer count is never followed by a count write
  p_zero_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OC_RD && cap && rzero) |=> !(mem_req_valid && mem_req_we));

  // R2: outer count write-back lands below the outer pointer
  p_outer_wr_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we && st == S_OC_WR)
      |-> (mem_req_addr == w0 - PW'(OFF_CNT)));

  // R1: no memory traffic while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !mem_req_valid);
endmodule

// File: tb/nlc_seq_tb.sv
`timescale 1ns/1ps
module nlc_seq_tb;
  localparam logic [15:0] P_FP0 = 16'h0003;
  localparam logic [15:0] P_FP1 = 16'h4000;
  localparam logic [15:0] P_VPC = 16'h1234;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, jump_i = 1'b0;
  logic        mem_req_valid, mem_req_ready, mem_req_we;
  logic [15:0] mem_req_addr;
  logic [7:0]  mem_req_wdata;
  logic [7:0]  mem_rdata = 8'h00;
  logic [15:0] fp0_o, fp1_o, vpc_o;
  logic        done_o;

  always #2 clk = ~clk;

  nlc_seq #(.DW(8), .RST_FP0(P_FP0), .RST_FP1(P_FP1), .RST_VPC(P_VPC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .jump_i(jump_i),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rdata(mem_rdata),
    .fp0_o(fp0_o), .fp1_o(fp1_o), .vpc_o(vpc_o), .done_o(done_o)
  );

  int total = 0, bad = 0;
  logic [7:0] mem [int];
  logic [7:0] refm [int];
  logic [15:0] h0 = P_FP0, h1 = P_FP1, hpc = P_VPC;
  logic [15:0] e0, e1, epc;
  bit pending = 0;
  bit finished = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit force_rdy = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rdm(input int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction
  function automatic logic [7:0] rdr(input int a);
    return refm.exists(a) ? refm[a] : 8'h00;
  endfunction
  function automatic logic [15:0] rwr(input logic [15:0] a);
    logic [15:0] a1 = a + 16'd1;
    return {rdr(int'(a1)), rdr(int'(a))};
  endfunction

  task automatic put(input int a, input logic [7:0] v);
    mem[a] = v; refm[a] = v;
  endtask
  task automatic putw(input int a, input logic [15:0] v);
    put(a, v[7:0]); put((a + 1) & 16'hFFFF, v[15:8]);
  endtask

  // behavioural reference: one step on the reference memory
  task automatic model(input bit jmp);
    logic [15:0] m0 = h0, m1 = h1, pc = hpc, a;
    logic [7:0]  c;
    a = m0 - 16'd4; c = rdr(int'(a));
    if (c == 8'h00) begin
      m0 = rwr(m0 - 16'd2);
      m1 = rwr(m0 - 16'd8);
      pc = rwr(m0 - 16'd6);
    end else begin
      refm[int'(a)] = c - 8'd1;
      a = m1 - 16'd4; c = rdr(int'(a));
      if (c == 8'h00) m1 = rwr(m1 - 16'd2);
      else refm[int'(a)] = c - 8'd1;
      if (jmp) pc = rwr(m1 - 16'd6);
    end
    e0 = m0; e1 = m1; epc = pc;
  endtask

  // memory responder
  assign mem_req_ready = lfsr[0] | lfsr[3] | force_rdy;
  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_we) mem[int'(mem_req_addr)] = mem_req_wdata;
      else mem_rdata <= rdm(int'(mem_req_addr));
    end
  end

  // per-cycle monitor
  bit hold_pend = 0;
  logic [15:0] hold_addr;
  logic hold_we;
  always @(negedge clk) if (rst_n && !finished) begin
    if (hold_pend)
      chk(mem_req_valid && mem_req_addr == hold_addr && mem_req_we == hold_we,
          "R10", "stalled request changed", {15'd0, mem_req_valid, mem_req_addr},
          {16'd1, hold_addr});
    hold_pend = mem_req_valid && !mem_req_ready;
    hold_addr = mem_req_addr;
    hold_we   = mem_req_we;
    if (done_o) begin
      chk(pending, "R9", "done without step", 1, 0);
      chk(fp0_o == e0, "R3", "fp0", fp0_o, e0);
      chk(fp1_o == e1, "R4_R5_R6", "fp1", fp1_o, e1);
      chk(vpc_o == epc, "R7", "vpc", vpc_o, epc);
      begin
        bit same = 1;
        foreach (refm[k]) if (rdm(k) != refm[k]) same = 0;
        chk(same, "R2_R6", "memory counts", 0, 0);
      end
      h0 = e0; h1 = e1; hpc = epc;
      pending = 0;
    end else if (fp0_o != h0 || fp1_o != h1 || vpc_o != hpc) begin
      chk(0, "R9", "outputs moved without done", {fp0_o, fp1_o}, {h0, h1});
    end
  end

  task automatic step(input bit jmp, input bit extra_start);
    model(jmp);
    @(negedge clk);
    start_i = 1; jump_i = jmp; pending = 1;
    @(negedge clk);
    start_i = 0; jump_i = ~jmp;   // R11: jump_i changes after start
    if (extra_start) begin
      @(negedge clk); start_i = 1;
      @(negedge clk); start_i = 0;
    end
    while (pending) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // descriptor layout (R8: wraps below zero)
    put(16'hFFFF, 8'd2);            // outer count at 0003-4
    putw(16'h0001, 16'h8010);       // outer link
    putw(16'h800C, 16'h0003);       // count 3 at 8010-4, link
    put(16'h800C, 8'd3);
    putw(16'h800E, 16'h0003);
    putw(16'h8008, 16'h4000);       // next fp1
    putw(16'h800A, 16'hBEEF);       // pc
    put(16'h3FFC, 8'd1);            // inner count
    putw(16'h3FFE, 16'h6000);       // inner link
    putw(16'h3FFA, 16'h1111);       // inner pc
    put(16'h5FFC, 8'd0);
    putw(16'h5FFE, 16'h4000);
    putw(16'h5FFA, 16'h2222);

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(fp0_o == P_FP0 && fp1_o == P_FP1 && vpc_o == P_VPC, "R1", "reset pointers",
        {fp0_o, fp1_o}, {P_FP0, P_FP1});
    chk(!done_o && !mem_req_valid, "R1", "reset outputs", {done_o, mem_req_valid}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!mem_req_valid, "R1", "idle quiet", mem_req_valid, 0);

    for (int i = 0; i < 24; i++) step(((i % 3) == 1), (i == 5));
    force_rdy = 1;
    for (int i = 0; i < 16; i++) step(i[0], (i == 3));
    // R9: no stray completion afterwards
    repeat (20) @(negedge clk);
    chk(!pending, "R9", "step left pending", pending, 0);
    summary();
  end
endmodule